// File: doc/BRIEF.md
# Dual-Mode Pulse Generator and Edge Timestamp Channel

This block is a single timer channel with two mutually exclusive personalities selected by a mode input. In generate mode a counter advances on prescaled clock ticks and its value is compared against a duty threshold to drive a pulse-width-modulated output. The count may either wrap at the period (edge-aligned) or ramp up and back down (center-aligned), and the active level can be inverted. Period, duty and alignment changes are staged and applied only at a cycle boundary.

In capture mode the same counter runs freely. An external pin is synchronised and optionally deglitched, and the selected edge kind (rising, falling or both) copies the counter into a capture holding register. A valid flag marks an unread capture and a miss flag records an overwrite. In either mode the selected edge event produces a one-cycle interrupt pulse and a one-cycle DMA request pulse, each gated by its own mask. The filtered pin level and the live counter value are exposed as status.

Top module: `pwmcap_channel`

## Requirements
- R1: After reset pwm_out, irq, dma_req, cap_valid and cap_miss are 0 and cnt_value is 0.
- R2: While enable is 1 the counter advances once every div_ratio+1 clock cycles.
- R3: With center_align=0 and 0 < duty_in < period_in, the output repeats every period_in ticks and is active for duty_in ticks of each repetition; the count runs 0 to period_in-1 and wraps.
- R4: In edge-aligned mode a duty of 0 gives an output that is never active, and a duty equal to or above the period gives an output that is always active.
- R5: With center_align=1 the count goes 0 up to the period and back down to 1. One repetition lasts 2*period ticks, and the output is active for 2*duty-1 ticks of it, where 1 <= duty <= period.
- R6: polarity_low=1 makes the active level 0. When enable is 0 or mode_cap is 1, pwm_out sits at the inactive level, which equals polarity_low.
- R7: A load strobe stores period_in and duty_in in staging registers. The running waveform takes them up only at the next cycle boundary, so the rest of the current cycle keeps the old duty.
- R8: With mode_cap=1 and enable=1 the counter counts ticks freely and pwm_out stays inactive.
- R9: edge_sel picks the event edge: 2'b01 rising, 2'b10 falling, 2'b11 both, 2'b00 none. In generate mode the edge is taken from the active-phase waveform; in capture mode it is taken from the filtered pin.
- R10: With filt_en=1 a pin change is accepted only after it differs from the filtered level for filt_thresh consecutive clocks (0 acts as 1). Shorter pulses are dropped, and pin_state shows the filtered level.
- R11: In capture mode each event copies the counter into cap_value and sets cap_valid. An event while cap_valid=1 without cap_ack in that cycle sets cap_miss. cap_ack clears both flags, unless an event arrives in the same cycle, in which case cap_valid stays 1 and cap_miss stays 0.
- R12: Each event pulses irq for one cycle if int_mask=1 and pulses dma_req for one cycle if dma_mask=1; the two masks act independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the channel |
| mode_cap | input | 1 | 0 generate, 1 capture |
| center_align | input | 1 | 0 edge-aligned, 1 center-aligned count |
| polarity_low | input | 1 | 1 makes the active level low |
| div_ratio | input | DIV_W | Tick every div_ratio+1 clocks |
| period_in | input | CNT_W | Period value to stage |
| duty_in | input | CNT_W | Duty value to stage |
| load | input | 1 | Stage period_in and duty_in |
| edge_sel | input | 2 | Event edge selection |
| filt_en | input | 1 | Enable pin deglitch filter |
| filt_thresh | input | FLT_W | Required stable clocks |
| cap_in | input | 1 | Capture pin |
| cap_ack | input | 1 | Acknowledge capture, clears flags |
| int_mask | input | 1 | Allow interrupt pulses |
| dma_mask | input | 1 | Allow DMA request pulses |
| pwm_out | output | 1 | Generated waveform |
| pin_state | output | 1 | Filtered pin level |
| cnt_value | output | CNT_W | Live counter |
| cap_value | output | CNT_W | Last captured count |
| cap_valid | output | 1 | Unacknowledged capture held |
| cap_miss | output | 1 | Capture overwritten before acknowledge |
| irq | output | 1 | Interrupt pulse |
| dma_req | output | 1 | DMA request pulse |

## Verification
A new capture event and a software acknowledge can land on the same clock edge. The acknowledge must not erase the fresh capture, and the overwrite must not count as a miss. The bench first leaves a capture unacknowledged. It then places a rising edge on the pin so that the event cycle, four clocks after the pin change through the synchroniser and filter register, coincides with a one-cycle cap_ack pulse. It expects cap_valid=1 and cap_miss=0 afterwards. Capture spacing is scored by queuing the expected count differences between driven edges and comparing them as interrupts arrive.

// File: rtl/pwmcap_pkg.sv
package pwmcap_pkg;
   typedef enum logic [1:0] {
      EV_NONE = 2'b00,
      EV_RISE = 2'b01,
      EV_FALL = 2'b10,
      EV_BOTH = 2'b11
   } ev_edge_e;

   function automatic logic ev_hit(ev_edge_e sel, logic rise, logic fall);
      return (sel[0] & rise) | (sel[1] & fall);
   endfunction
endpackage

// File: rtl/pwmcap_prescaler.sv
module pwmcap_prescaler #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div_ratio,
   output logic             tick
);
   logic [DIV_W-1:0] pc;

   assign tick = run && (pc >= div_ratio);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            pc <= '0;
      else if (!run || tick) pc <= '0;
      else                   pc <= pc + DIV_W'(1);
   end

   AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && div_ratio != '0) |=> (!tick || div_ratio == '0)); // R2
endmodule

// File: rtl/pwmcap_filter.sv
module pwmcap_filter #(
   parameter int SYNC_N = 2,
   parameter int FLT_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             din,
   input  logic             filt_en,
   input  logic [FLT_W-1:0] thresh,
   output logic             dout
);
   logic [SYNC_N-1:0] sq;
   logic              sync_lvl;
   logic              lvl_q;
   logic [FLT_W-1:0]  run_cnt;
   logic [FLT_W:0]    cnt_nx;
   logic [FLT_W:0]    thr_eff;

   generate
      if (SYNC_N == 1) begin : g_sync_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sq <= '0;
            else        sq <= din;
         end
      end else begin : g_sync_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sq <= '0;
            else        sq <= {sq[SYNC_N-2:0], din};
         end
      end
   endgenerate

   assign sync_lvl = sq[SYNC_N-1];
   assign cnt_nx   = {1'b0, run_cnt} + (FLT_W+1)'(1);
   assign thr_eff  = (thresh == '0) ? (FLT_W+1)'(1) : {1'b0, thresh};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q   <= 1'b0;
         run_cnt <= '0;
      end else if (sync_lvl == lvl_q) begin
         run_cnt <= '0;
      end else if (!filt_en || cnt_nx >= thr_eff) begin
         lvl_q   <= sync_lvl;
         run_cnt <= '0;
      end else begin
         run_cnt <= run_cnt + FLT_W'(1);
      end
   end

   assign dout = lvl_q;

   AST_FILT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_lvl == lvl_q) |=> $stable(lvl_q)); // R10
endmodule

// File: rtl/pwmcap_counter.sv
module pwmcap_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_gen,
   input  logic             run_cap,
   input  logic             tick,
   input  logic             load,
   input  logic             center_in,
   input  logic [CNT_W-1:0] period_in,
   input  logic [CNT_W-1:0] duty_in,
   output logic [CNT_W-1:0] cnt,
   output logic             active
);
   logic [CNT_W-1:0] per_s, duty_s, per_a, duty_a;
   logic             ctr_a, down, m_q;
   logic             idle, reload;
   logic [CNT_W:0]   cnt_inc;

   assign cnt_inc = {1'b0, cnt} + (CNT_W+1)'(1);
   assign idle    = (!run_gen && !run_cap) || (run_cap != m_q);
   assign reload  = run_gen && !idle && tick &&
                    ((!ctr_a && cnt_inc >= {1'b0, per_a}) ||
                     ( ctr_a && !down && cnt >= per_a && cnt == '0) ||
                     ( ctr_a &&  down && cnt <= CNT_W'(1)));
   assign active  = run_gen && !idle && (cnt < duty_a);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_s <= '0; duty_s <= '0; per_a <= '0; duty_a <= '0;
         ctr_a <= 1'b0; down <= 1'b0; m_q <= 1'b0; cnt <= '0;
      end else begin
         m_q <= run_cap;
         if (load) begin
            per_s  <= period_in;
            duty_s <= duty_in;
         end
         if (idle) begin
            cnt <= '0; down <= 1'b0;
            per_a <= per_s; duty_a <= duty_s; ctr_a <= center_in;
         end else if (run_cap) begin
            if (tick) cnt <= cnt + CNT_W'(1);
         end else if (reload) begin
            cnt <= '0; down <= 1'b0;
            per_a <= per_s; duty_a <= duty_s; ctr_a <= center_in;
         end else if (tick) begin
            if (!ctr_a)            cnt <= cnt + CNT_W'(1);
            else if (down)         cnt <= cnt - CNT_W'(1);
            else if (cnt >= per_a) begin
               down <= 1'b1;
               cnt  <= cnt - CNT_W'(1);
            end else               cnt <= cnt + CNT_W'(1);
         end
      end
   end

   AST_EDGE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (run_gen && !idle && !ctr_a && per_a != '0) |-> (cnt < per_a)); // R3
   AST_CENTER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (run_gen && !idle && ctr_a) |-> (cnt <= per_a)); // R5
   AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (run_gen && !idle && !reload) |=> ($stable(duty_a) && $stable(per_a))); // R7
endmodule

// File: rtl/pwmcap_channel.sv
module pwmcap_channel
   import pwmcap_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int DIV_W  = 8,
   parameter int FLT_W  = 4,
   parameter int SYNC_N = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             mode_cap,
   input  logic             center_align,
   input  logic             polarity_low,
   input  logic [DIV_W-1:0] div_ratio,
   input  logic [CNT_W-1:0] period_in,
   input  logic [CNT_W-1:0] duty_in,
   input  logic             load,
   input  logic [1:0]       edge_sel,
   input  logic             filt_en,
   input  logic [FLT_W-1:0] filt_thresh,
   input  logic             cap_in,
   input  logic             cap_ack,
   input  logic             int_mask,
   input  logic             dma_mask,
   output logic             pwm_out,
   output logic             pin_state,
   output logic [CNT_W-1:0] cnt_value,
   output logic [CNT_W-1:0] cap_value,
   output logic             cap_valid,
   output logic             cap_miss,
   output logic             irq,
   output logic             dma_req
);
   initial begin
      AST_PARAMS: assert (CNT_W >= 2 && DIV_W >= 1 && FLT_W >= 1 && SYNC_N >= 1)
         else $error("pwmcap_channel: parameter out of range");
   end

   logic             run_gen, run_cap, tick, gen_active, pin_lvl;
   logic             src_lvl, prev_q, ev, cap_ev;
   logic [CNT_W-1:0] cnt;

   assign run_gen = enable & ~mode_cap;
   assign run_cap = enable &  mode_cap;

   pwmcap_prescaler #(.DIV_W(DIV_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(enable), .div_ratio(div_ratio), .tick(tick));

   pwmcap_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run_gen(run_gen), .run_cap(run_cap), .tick(tick),
      .load(load), .center_in(center_align), .period_in(period_in), .duty_in(duty_in),
      .cnt(cnt), .active(gen_active));

   pwmcap_filter #(.SYNC_N(SYNC_N), .FLT_W(FLT_W)) u_flt (
      .clk(clk), .rst_n(rst_n), .din(cap_in), .filt_en(filt_en),
      .thresh(filt_thresh), .dout(pin_lvl));

   assign src_lvl = run_gen ? gen_active : pin_lvl;
   assign ev      = enable && ev_hit(ev_edge_e'(edge_sel), src_lvl & ~prev_q, ~src_lvl & prev_q);
   assign cap_ev  = ev & run_cap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0; pwm_out <= 1'b0; irq <= 1'b0; dma_req <= 1'b0;
         cap_value <= '0; cap_valid <= 1'b0; cap_miss <= 1'b0;
      end else begin
         prev_q  <= enable ? src_lvl : 1'b0;
         pwm_out <= run_gen ? (gen_active ^ polarity_low) : polarity_low;
         irq     <= ev & int_mask;
         dma_req <= ev & dma_mask;
         if (cap_ev) begin
            cap_value <= cnt;
            cap_valid <= 1'b1;
            cap_miss  <= (cap_miss | cap_valid) & ~cap_ack;
         end else if (cap_ack) begin
            cap_valid <= 1'b0;
            cap_miss  <= 1'b0;
         end
      end
   end

   assign pin_state = pin_lvl;
   assign cnt_value = cnt;

   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      !int_mask |=> !irq); // R12
   AST_DMA_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      !dma_mask |=> !dma_req); // R12
   AST_MISS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_ev && cap_valid && !cap_ack) |=> cap_miss); // R11
   AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_ev |=> $stable(cap_value)); // R11
   AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      !run_gen |=> (pwm_out == $past(polarity_low))); // R6
endmodule

// File: tb/sim_pwmcap_channel.sv
module sim_pwmcap_channel;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 0, mode_cap = 0, center_align = 0, polarity_low = 0;
   logic [7:0]  div_ratio = '0;
   logic [31:0] period_in = '0, duty_in = '0;
   logic        load = 0;
   logic [1:0]  edge_sel = 2'b00;
   logic        filt_en = 0;
   logic [3:0]  filt_thresh = '0;
   logic        cap_in = 0, cap_ack = 0, int_mask = 0, dma_mask = 0;
   logic        pwm_out, pin_state, cap_valid, cap_miss, irq, dma_req;
   logic [31:0] cnt_value, cap_value;

   int errors = 0, checks = 0;
   int irq_cnt = 0, dma_cnt = 0, cap_seen = 0;
   bit mon_on = 0, have_prev = 0;
   logic [31:0] prev_cap;
   int exp_q[$];

   always #2 clk = ~clk;

   pwmcap_channel u0 (
      .clk(clk), .rst_n(rst_n), .enable(enable), .mode_cap(mode_cap),
      .center_align(center_align), .polarity_low(polarity_low), .div_ratio(div_ratio),
      .period_in(period_in), .duty_in(duty_in), .load(load), .edge_sel(edge_sel),
      .filt_en(filt_en), .filt_thresh(filt_thresh), .cap_in(cap_in), .cap_ack(cap_ack),
      .int_mask(int_mask), .dma_mask(dma_mask), .pwm_out(pwm_out), .pin_state(pin_state),
      .cnt_value(cnt_value), .cap_value(cap_value), .cap_valid(cap_valid),
      .cap_miss(cap_miss), .irq(irq), .dma_req(dma_req));

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic count_high(input int win, output int hi);
      hi = 0;
      repeat (win) begin
         @(negedge clk);
         if (pwm_out) hi++;
      end
      @(posedge clk); #1;
   endtask

   task automatic set_gen(input int p, input int d, input bit ctr, input int dv, input bit pol);
      enable = 0; mode_cap = 0;
      period_in = p; duty_in = d; load = 1;
      step(1);
      load = 0; center_align = ctr; div_ratio = dv[7:0]; polarity_low = pol;
      step(2);
      enable = 1;
      step(40);
   endtask

   task automatic set_cap(input logic [1:0] es, input bit fe, input int th);
      enable = 0; mode_cap = 1; cap_in = 0; div_ratio = '0;
      edge_sel = es; filt_en = fe; filt_thresh = th[3:0];
      step(4);
      enable = 1;
      step(4);
   endtask

   task automatic pulse(input int hi, input int lo);
      cap_in = 1; step(hi);
      cap_in = 0; step(lo);
   endtask

   task automatic ack();
      cap_ack = 1; step(1); cap_ack = 0;
   endtask

   // scoreboard monitor: capture spacing compared against the driver's queue
   always @(negedge clk) begin
      if (irq) irq_cnt++;
      if (dma_req) dma_cnt++;
      if (mon_on && irq) begin
         cap_seen++;
         if (have_prev) begin
            if (exp_q.size() == 0) check(0, "R11 unexpected capture", cap_value - prev_cap, 0);
            else begin
               int e;
               e = exp_q.pop_front();
               check((cap_value - prev_cap) == e, "R11 capture spacing", cap_value - prev_cap, e);
            end
         end
         have_prev = 1;
         prev_cap  = cap_value;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int hi, i0, c0;
      step(3);
      rst_n = 1;
      @(negedge clk);
      check(pwm_out == 0 && irq == 0 && dma_req == 0, "R1 outputs at reset", {pwm_out, irq, dma_req}, 0);
      check(cap_valid == 0 && cap_miss == 0 && cnt_value == 0, "R1 flags and count at reset",
            {cap_valid, cap_miss, cnt_value}, 0);

      // R3 edge-aligned, plus R9/R12 generate-mode rising events
      edge_sel = 2'b01; int_mask = 1;
      set_gen(10, 3, 0, 0, 0);
      i0 = irq_cnt;
      count_high(100, hi);
      check(hi == 30, "R3 edge-aligned active time", hi, 30);
      check(irq_cnt - i0 == 10, "R9 one rising event per period", irq_cnt - i0, 10);
      int_mask = 0; edge_sel = 2'b00;

      set_gen(5, 2, 0, 1, 0);
      count_high(120, hi);
      check(hi == 48, "R2 divide by two stretches ticks", hi, 48);

      set_gen(6, 2, 1, 0, 0);
      count_high(120, hi);
      check(hi == 30, "R5 center-aligned active time", hi, 30);

      set_gen(10, 3, 0, 0, 1);
      count_high(100, hi);
      check(hi == 70, "R6 inverted polarity", hi, 70);

      set_gen(10, 0, 0, 0, 0);
      count_high(100, hi);
      check(hi == 0, "R4 zero duty never active", hi, 0);
      set_gen(10, 12, 0, 0, 0);
      count_high(100, hi);
      check(hi == 100, "R4 duty above period always active", hi, 100);
      set_gen(10, 10, 0, 0, 0);
      count_high(100, hi);
      check(hi == 100, "R4 duty equal period always active", hi, 100);

      // R7 staged update mid-cycle
      set_gen(20, 5, 0, 0, 0);
      for (int k = 0; k < 100 && cnt_value != 5; k++) @(negedge clk);
      duty_in = 15; load = 1;
      @(posedge clk); #1 load = 0;
      hi = 0;
      repeat (12) begin @(negedge clk); if (pwm_out) hi++; end
      check(hi == 0, "R7 old duty kept to cycle end", hi, 0);
      step(30);
      count_high(60, hi);
      check(hi == 45, "R7 new duty after boundary", hi, 45);

      // R8 capture mode free-running counter, output parked
      polarity_low = 0;
      set_cap(2'b00, 0, 0);
      @(negedge clk); c0 = cnt_value;
      repeat (10) @(negedge clk);
      check(cnt_value - c0 == 10, "R8 free-running count", cnt_value - c0, 10);
      check(pwm_out == 0, "R8 output inactive in capture", pwm_out, 0);
      enable = 0; div_ratio = 8'd2; step(2); enable = 1; step(3);
      @(negedge clk); c0 = cnt_value;
      repeat (30) @(negedge clk);
      check(cnt_value - c0 == 10, "R2 divide by three in capture", cnt_value - c0, 10);

      // R9/R11 rising captures through the scoreboard
      set_cap(2'b01, 0, 0);
      int_mask = 1; have_prev = 0; cap_seen = 0; mon_on = 1;
      pulse(3, 10); exp_q.push_back(13);
      pulse(5, 20); exp_q.push_back(25);
      pulse(4, 12);
      check(cap_seen == 3 && exp_q.size() == 0, "R9 rising captures consumed", cap_seen, 3);
      check(cap_valid == 1 && cap_miss == 1, "R11 overwrite sets miss", {cap_valid, cap_miss}, 3);
      ack(); @(negedge clk);
      check(cap_valid == 0 && cap_miss == 0, "R11 acknowledge clears flags", {cap_valid, cap_miss}, 0);

      // R9 falling and both
      edge_sel = 2'b10; have_prev = 0; cap_seen = 0;
      pulse(3, 10); exp_q.push_back(15);
      pulse(5, 12);
      check(cap_seen == 2 && exp_q.size() == 0, "R9 falling captures consumed", cap_seen, 2);
      edge_sel = 2'b11; have_prev = 0; cap_seen = 0;
      exp_q.push_back(4); exp_q.push_back(6); exp_q.push_back(9);
      pulse(4, 6); pulse(9, 12);
      check(cap_seen == 4 && exp_q.size() == 0, "R9 both edges captured", cap_seen, 4);
      ack();

      // R10 glitch filter
      mon_on = 0;
      set_cap(2'b01, 1, 4);
      int_mask = 1;
      i0 = irq_cnt;
      pulse(2, 12);
      check(irq_cnt == i0, "R10 short glitch dropped", irq_cnt - i0, 0);
      check(pin_state == 0, "R10 filtered level stays low", pin_state, 0);
      have_prev = 0; cap_seen = 0; mon_on = 1;
      pulse(8, 12); exp_q.push_back(20);
      pulse(6, 12);
      check(cap_seen == 2 && exp_q.size() == 0, "R10 long pulses accepted", cap_seen, 2);
      mon_on = 0;
      cap_in = 1; step(8);
      check(pin_state == 1, "R10 pin_state follows filtered pin", pin_state, 1);
      cap_in = 0; step(10); ack();

      // R12 DMA only
      int_mask = 0; dma_mask = 1;
      i0 = irq_cnt; c0 = dma_cnt;
      pulse(6, 12);
      check(irq_cnt == i0 && dma_cnt == c0 + 1, "R12 masked irq, dma pulse",
            (irq_cnt - i0) * 10 + (dma_cnt - c0), 1);
      dma_mask = 0;

      // R11 capture and acknowledge in the same cycle
      set_cap(2'b01, 0, 0);
      pulse(3, 8);
      check(cap_valid == 1, "R11 capture held before collision", cap_valid, 1);
      cap_in = 1;
      @(posedge clk); @(posedge clk); @(posedge clk); #1 cap_ack = 1;
      @(posedge clk); #1 cap_ack = 0;
      @(negedge clk);
      check(cap_valid == 1 && cap_miss == 0, "R11 event wins over same-cycle ack",
            {cap_valid, cap_miss}, 2);
      cap_in = 0; step(5);

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule